// File: doc/BRIEF.md
# Multi-Group Maskable Interrupt Aggregator

This block collects thirty-two single-bit event sources into one interrupt line for a host processor. The sources are arranged as four groups of eight bits. Each source has a latched status bit and a mask bit. In the first three groups, each source has a fixed sensitivity: rising edge, falling edge, both edges, or level. In the fourth group, the host programs rising-edge and falling-edge detection separately for each bit. Before detection, every source passes through a synchronizer.

The host reaches the block through a simple synchronous register port. Read data returns one cycle after the read strobe. The host polls the status registers to find out which sources fired. It then clears them, either by reading them or by writing ones, depending on a single global mode bit.

The interrupt line has programmable polarity. A control bit can hold the line inactive while the device sleeps. A separate wake-request output tells a power controller that something deserves a switch-on. Some sources raise this request even when they are masked. Others raise it only when unmasked. An asserted interrupt line also raises it.

Top module: `irq_hub`

## Requirements
- R1: After reset, all status, mask, edge-enable and control registers read 0, `irq_o` is 1 (inactive, active low) and `on_req_o` is 0.
- R2: Fixed sensitivities apply as follows:
  - Group 0 bits 6..4 latch on both edges.
  - Group 0 bits 3..1 latch on falling edges only.
  - Group 1 bits 6, 4, 2, 1 and 0 latch on rising edges only.
  - Group 2 bit 7 latches on both edges, and group 2 bits 2..0 latch while the input is high.
  - All other bits never latch.
- R3: In group 3, bit i latches on a rising edge when bit i of the rise-enable register is 1, and on a falling edge when bit i of the fall-enable register is 1. If both are 1, it latches on either edge. If neither is 1, it never latches.
- R4: While a source's mask bit is 1, its events do not set its status bit and do not assert the line. Such events are lost: unmasking later does not recover them.
- R5: A status bit that is already set stays set after its mask bit is set, until the host clears it.
- R6: The line is active whenever any status bit is set (except as allowed by R12). It goes inactive only once every status bit is 0.
- R7: Control bit 0 selects the polarity of the line: 0 means active low, 1 means active high.
- R8: Control bit 1 selects the clear method:
  - When it is 0, a status read returns the bits and then clears them, and writes to status registers are ignored.
  - When it is 1, reads do not clear, and writing a 1 clears the matching status bit.
- R9: If a source event and a host clear hit the same status bit in the same cycle, the bit ends up set.
- R10: Group 0 bits 3 and 1 raise `on_req_o` on every detected event, whether masked or not.
- R11: `on_req_o` is also raised in two further cases:
  - by events on group 1 bits 6, 1 and 0, and on any bit of groups 2 and 3, but only while unmasked;
  - whenever the line is active.
  Any other event does not raise it.
- R12: When control bit 2 is 1 and `sleep_i` is 1, the line is held inactive. Status bits still latch, and the line becomes active once `sleep_i` falls.
- R13: Register addresses are as follows: status of group g at g, mask of group g at 4+g, rise-enable at 8, fall-enable at 9, control at 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Event sources; group g occupies bits 8g+7..8g |
| sleep_i | input | 1 | Device is in sleep state |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data, valid the cycle after a read strobe |
| irq_o | output | 1 | Interrupt line, polarity per control bit 0 |
| on_req_o | output | 1 | Wake/switch-on request |

## Verification
The hardest case to reach is a source event and a host clear landing on the same status bit in the same cycle. The synchronizer and the edge history put three register stages between a pin and its status bit. To line them up, the bench toggles the pin and then issues the write-one-to-clear exactly two falling edges later, which makes the clear coincide with the latching edge. A second subtle case is the masked wake request, which is only a one-cycle pulse. The bench counts every cycle in which `on_req_o` is high, so a pulse from a masked source is never missed. The sleep suppression and the masked wake-source cases are combined, which shows that a request from a wake source reaches the output while the line itself is held off.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

   localparam int unsigned REG_AW = 4;
   localparam int unsigned REG_DW = 8;

   localparam logic [REG_AW-1:0] A_STAT_BASE = 4'h0;
   localparam logic [REG_AW-1:0] A_MASK_BASE = 4'h4;
   localparam logic [REG_AW-1:0] A_RISE_EN   = 4'h8;
   localparam logic [REG_AW-1:0] A_FALL_EN   = 4'h9;
   localparam logic [REG_AW-1:0] A_CTRL      = 4'hA;

   // control word, bit 2 down to bit 0
   typedef struct packed {
      logic sleep_quiet;
      logic clr_on_wr;
      logic pol_high;
   } ctrl_t;

endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
   parameter int unsigned N         = 32,
   parameter int unsigned GW        = 8,
   parameter int unsigned STAGES    = 2,
   parameter logic [N-GW-1:0] RISE_FIX  = '0,
   parameter logic [N-GW-1:0] FALL_FIX  = '0,
   parameter logic [N-GW-1:0] LEVEL_FIX = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  src_i,
   input  logic [GW-1:0] rise_en_i,
   input  logic [GW-1:0] fall_en_i,
   output logic [N-1:0]  evt_o
);
   localparam int unsigned PROG_LO = N - GW;

   logic [N-1:0] sync_q [STAGES];
   logic [N-1:0] prev_q;
   logic [N-1:0] cur_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) sync_q[k] <= '0;
         prev_q <= '0;
      end else begin
         sync_q[0] <= src_i;
         for (int k = 1; k < STAGES; k++) sync_q[k] <= sync_q[k-1];
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign cur_w = sync_q[STAGES-1];

   for (genvar i = 0; i < N; i++) begin : g_det
      if (i >= PROG_LO) begin : g_prog
         assign evt_o[i] = (rise_en_i[i-PROG_LO] &  cur_w[i] & ~prev_q[i])
                         | (fall_en_i[i-PROG_LO] & ~cur_w[i] &  prev_q[i]);
      end else if (LEVEL_FIX[i]) begin : g_level
         assign evt_o[i] = cur_w[i];
      end else begin : g_edge
         assign evt_o[i] = (RISE_FIX[i] &  cur_w[i] & ~prev_q[i])
                         | (FALL_FIX[i] & ~cur_w[i] &  prev_q[i]);
      end
   end

   // R3
   prog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rise_en_i | fall_en_i) == '0) |-> (evt_o[N-1 -: GW] == '0));

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int unsigned N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt_i,
   input  logic [N-1:0] mask_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] status_o
);
   logic [N-1:0] st_q;
   logic [N-1:0] set_w;

   assign set_w = evt_i & ~mask_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= (st_q & ~clr_i) | set_w;
   end

   assign status_o = st_q;

   // R4
   masked_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((st_q & ~$past(st_q) & $past(mask_i)) == '0));

   // R5
   held_until_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(st_q & ~clr_i) & ~st_q) == '0));

   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_i & ~mask_i) != '0) |=> ((st_q & $past(evt_i & ~mask_i)) == $past(evt_i & ~mask_i)));

endmodule

// File: rtl/irq_host_regs.sv
module irq_host_regs
   import irq_hub_pkg::*;
#(
   parameter int unsigned GROUPS = 4,
   parameter int unsigned GW     = 8,
   localparam int unsigned N     = GROUPS * GW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic              re_i,
   input  logic [REG_AW-1:0] addr_i,
   input  logic [REG_DW-1:0] wdata_i,
   input  logic [N-1:0]      status_i,
   output logic [REG_DW-1:0] rdata_o,
   output logic [N-1:0]      mask_o,
   output logic [N-1:0]      clr_o,
   output logic [GW-1:0]     rise_en_o,
   output logic [GW-1:0]     fall_en_o,
   output ctrl_t             ctrl_o
);
   logic [N-1:0]      mask_q;
   logic [GW-1:0]     rise_q;
   logic [GW-1:0]     fall_q;
   ctrl_t             ctrl_q;
   logic [REG_DW-1:0] rdata_q;
   logic [REG_DW-1:0] rd_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         rise_q <= '0;
         fall_q <= '0;
         ctrl_q <= '0;
      end else if (we_i) begin
         for (int g = 0; g < GROUPS; g++) begin
            if (addr_i == A_MASK_BASE + REG_AW'(g)) mask_q[g*GW +: GW] <= wdata_i[GW-1:0];
         end
         if (addr_i == A_RISE_EN) rise_q <= wdata_i[GW-1:0];
         if (addr_i == A_FALL_EN) fall_q <= wdata_i[GW-1:0];
         if (addr_i == A_CTRL)    ctrl_q <= ctrl_t'(wdata_i[2:0]);
      end
   end

   always_comb begin
      rd_nxt = '0;
      for (int g = 0; g < GROUPS; g++) begin
         if (addr_i == A_STAT_BASE + REG_AW'(g)) rd_nxt[GW-1:0] = status_i[g*GW +: GW];
         if (addr_i == A_MASK_BASE + REG_AW'(g)) rd_nxt[GW-1:0] = mask_q[g*GW +: GW];
      end
      if (addr_i == A_RISE_EN) rd_nxt[GW-1:0] = rise_q;
      if (addr_i == A_FALL_EN) rd_nxt[GW-1:0] = fall_q;
      if (addr_i == A_CTRL)    rd_nxt[2:0]    = ctrl_q;
   end

   always_comb begin
      clr_o = '0;
      for (int g = 0; g < GROUPS; g++) begin
         if (addr_i == A_STAT_BASE + REG_AW'(g)) begin
            if (ctrl_q.clr_on_wr && we_i)
               clr_o[g*GW +: GW] = wdata_i[GW-1:0];
            else if (!ctrl_q.clr_on_wr && re_i)
               clr_o[g*GW +: GW] = status_i[g*GW +: GW];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata_q <= '0;
      else if (re_i) rdata_q <= rd_nxt;
   end

   assign rdata_o   = rdata_q;
   assign mask_o    = mask_q;
   assign rise_en_o = rise_q;
   assign fall_en_o = fall_q;
   assign ctrl_o    = ctrl_q;

   // R8
   read_keeps_in_wr_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.clr_on_wr && re_i && !we_i) |-> (clr_o == '0));

endmodule

// File: rtl/irq_hub.sv
module irq_hub
   import irq_hub_pkg::*;
#(
   parameter int unsigned GROUPS      = 4,
   parameter int unsigned GW          = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [(GROUPS-1)*GW-1:0] FIX_RISE  = 24'h80_57_70,
   parameter logic [(GROUPS-1)*GW-1:0] FIX_FALL  = 24'h80_00_7E,
   parameter logic [(GROUPS-1)*GW-1:0] FIX_LEVEL = 24'h07_00_00,
   parameter logic [GROUPS*GW-1:0]     WAKE_ALWAYS   = 32'h0000_000A,
   parameter logic [GROUPS*GW-1:0]     WAKE_UNMASKED = 32'hFFFF_4300
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [GROUPS*GW-1:0] src_i,
   input  logic                 sleep_i,
   input  logic                 reg_we_i,
   input  logic                 reg_re_i,
   input  logic [REG_AW-1:0]    reg_addr_i,
   input  logic [REG_DW-1:0]    reg_wdata_i,
   output logic [REG_DW-1:0]    reg_rdata_o,
   output logic                 irq_o,
   output logic                 on_req_o
);
   localparam int unsigned N = GROUPS * GW;

   if (GROUPS < 2 || GROUPS > 4) begin : g_bad_groups
      $error("irq_hub: GROUPS must lie in 2..4");
   end
   if (GW < 3 || GW > REG_DW) begin : g_bad_width
      $error("irq_hub: GW must lie in 3..REG_DW");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_hub: SYNC_STAGES must be at least 2");
   end

   logic [N-1:0]  evt_w;
   logic [N-1:0]  mask_w;
   logic [N-1:0]  clr_w;
   logic [N-1:0]  status_w;
   logic [GW-1:0] rise_en_w;
   logic [GW-1:0] fall_en_w;
   ctrl_t         ctrl_w;
   logic          any_st_w;
   logic          line_act_w;
   logic          wake_w;
   logic          irq_q;
   logic          on_q;

   irq_src_sync #(
      .N(N), .GW(GW), .STAGES(SYNC_STAGES),
      .RISE_FIX(FIX_RISE), .FALL_FIX(FIX_FALL), .LEVEL_FIX(FIX_LEVEL)
   ) u_sync (
      .clk(clk), .rst_n(rst_n), .src_i(src_i),
      .rise_en_i(rise_en_w), .fall_en_i(fall_en_w), .evt_o(evt_w)
   );

   irq_status_bank #(.N(N)) u_bank (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_w), .mask_i(mask_w),
      .clr_i(clr_w), .status_o(status_w)
   );

   irq_host_regs #(.GROUPS(GROUPS), .GW(GW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .re_i(reg_re_i),
      .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .status_i(status_w),
      .rdata_o(reg_rdata_o), .mask_o(mask_w), .clr_o(clr_w),
      .rise_en_o(rise_en_w), .fall_en_o(fall_en_w), .ctrl_o(ctrl_w)
   );

   assign any_st_w   = |status_w;
   assign line_act_w = any_st_w & ~(ctrl_w.sleep_quiet & sleep_i);
   assign wake_w     = (|(evt_w & WAKE_ALWAYS))
                     | (|(evt_w & ~mask_w & WAKE_UNMASKED))
                     | line_act_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b1;
         on_q  <= 1'b0;
      end else begin
         irq_q <= ctrl_w.pol_high ? line_act_w : ~line_act_w;
         on_q  <= wake_w;
      end
   end

   assign irq_o    = irq_q;
   assign on_req_o = on_q;

   // R6
   idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_st_w) |=> (irq_o == !$past(ctrl_w.pol_high)));

   // R6
   busy_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_st_w && !(sleep_i && ctrl_w.sleep_quiet)) |=> (irq_o == $past(ctrl_w.pol_high)));

   // R12
   sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_i && ctrl_w.sleep_quiet) |=> (irq_o == !$past(ctrl_w.pol_high)));

   // R10
   wake_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_w & WAKE_ALWAYS) != '0) |=> on_req_o);

endmodule

// File: tb/irq_hub_bench.sv
module irq_hub_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src = '0;
   logic        sleep = 1'b0;
   logic        we = 1'b0;
   logic        re = 1'b0;
   logic [3:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        irq;
   logic        on_req;

   int checks = 0;
   int errors = 0;
   int on_cnt = 0;
   bit done = 1'b0;
   logic rd_fire_q = 1'b0;

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } rd_item_t;
   rd_item_t sb_q[$];

   always #2.5 clk = ~clk;

   irq_hub u_irq_hub (
      .clk(clk), .rst_n(rst_n), .src_i(src), .sleep_i(sleep),
      .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .irq_o(irq), .on_req_o(on_req)
   );

   always @(posedge clk) begin
      rd_fire_q <= re;
      if (on_req) on_cnt <= on_cnt + 1;
   end

   // monitor: compare read data against the scoreboard
   always @(negedge clk) begin
      if (rd_fire_q) begin
         checks++;
         if (sb_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard: unexpected read actual=%h expected=none", rdata);
         end else begin
            rd_item_t it;
            it = sb_q.pop_front();
            if (rdata !== it.exp) begin
               errors++;
               $display("FAIL %s: actual=%h expected=%h", it.tag, rdata, it.exp);
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_src(input int idx, input logic v);
      @(negedge clk);
      src[idx] = v;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
      rd_item_t it;
      @(negedge clk);
      it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      re = 1'b1; addr = a;
      @(negedge clk);
      re = 1'b0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      int snap;
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(3);

      // R1 reset state, R13 map
      chk(irq == 1'b1, "R1 irq idle", irq, 1);
      chk(on_req == 1'b0, "R1 on_req idle", on_req, 0);
      for (int a = 0; a <= 10; a++) rd(4'(a), 8'h00, "R1 R13 reset read");

      // R2 fixed sensitivities
      set_src(6, 1'b1); wait_cyc(8);
      chk(irq == 1'b0, "R6 line active", irq, 0);
      rd(0, 8'h40, "R2 g0b6 rise");
      wait_cyc(4);
      chk(irq == 1'b1, "R6 R8 line off after read-clear", irq, 1);
      set_src(6, 1'b0); wait_cyc(8);
      rd(0, 8'h40, "R2 g0b6 fall");
      set_src(3, 1'b1); wait_cyc(8);
      rd(0, 8'h00, "R2 g0b3 no rise");
      set_src(3, 1'b0); wait_cyc(8);
      rd(0, 8'h08, "R2 g0b3 fall");
      set_src(12, 1'b1); wait_cyc(8);
      rd(1, 8'h10, "R2 g1b4 rise");
      set_src(12, 1'b0); wait_cyc(8);
      rd(1, 8'h00, "R2 g1b4 no fall");
      set_src(16, 1'b1); set_src(16, 1'b0); wait_cyc(8);
      rd(2, 8'h01, "R2 g2b0 level pulse");
      set_src(23, 1'b1); wait_cyc(8);
      rd(2, 8'h80, "R2 g2b7 rise");
      set_src(23, 1'b0); wait_cyc(8);
      rd(2, 8'h80, "R2 g2b7 fall");

      // R3 programmable edges
      wr(8, 8'h05); wr(9, 8'h06);
      rd(8, 8'h05, "R13 rise enable");
      rd(9, 8'h06, "R13 fall enable");
      @(negedge clk); src[27:24] = 4'hF; wait_cyc(8);
      rd(3, 8'h05, "R3 rising");
      @(negedge clk); src[27:24] = 4'h0; wait_cyc(8);
      rd(3, 8'h06, "R3 falling");

      // R4 masked event lost
      wr(5, 8'h10);
      set_src(12, 1'b1); wait_cyc(8);
      chk(irq == 1'b1, "R4 masked no line", irq, 1);
      rd(1, 8'h00, "R4 masked no status");
      wr(5, 8'h00); wait_cyc(4);
      rd(1, 8'h00, "R4 event lost");
      set_src(12, 1'b0); wait_cyc(8);

      // R5 / R8 write-one-to-clear mode
      wr(10, 8'h02);
      set_src(8, 1'b1); wait_cyc(8);
      wr(5, 8'h01);
      set_src(8, 1'b0); wait_cyc(4);
      set_src(8, 1'b1); wait_cyc(8);
      rd(1, 8'h01, "R8 read does not clear");
      rd(1, 8'h01, "R5 held after mask");
      chk(irq == 1'b0, "R5 R6 line held", irq, 0);
      wr(1, 8'h01); wait_cyc(4);
      rd(1, 8'h00, "R8 write one clears");
      chk(irq == 1'b1, "R6 line off after clear", irq, 1);
      wr(5, 8'h00);
      set_src(8, 1'b0); wait_cyc(8);

      // R9 set wins over simultaneous clear
      set_src(8, 1'b1); wait_cyc(8);
      set_src(8, 1'b0); wait_cyc(8);
      @(negedge clk); src[8] = 1'b1;
      @(negedge clk);
      @(negedge clk); we = 1'b1; addr = 4'd1; wdata = 8'h01;
      @(negedge clk); we = 1'b0;
      wait_cyc(4);
      rd(1, 8'h01, "R9 set wins");
      wr(1, 8'h01); wait_cyc(4);
      rd(1, 8'h00, "R9 later clear");
      set_src(8, 1'b0); wait_cyc(8);

      // R7 polarity, R8 write ignored in read-clear mode
      wr(10, 8'h01); wait_cyc(4);
      chk(irq == 1'b0, "R7 active-high idle", irq, 0);
      set_src(6, 1'b1); wait_cyc(8);
      chk(irq == 1'b1, "R7 active-high asserted", irq, 1);
      wr(0, 8'hFF); wait_cyc(4);
      chk(irq == 1'b1, "R8 write ignored in read-clear mode", irq, 1);
      rd(0, 8'h40, "R8 status survives write");
      wait_cyc(4);
      chk(irq == 1'b0, "R7 deasserted low", irq, 0);
      set_src(6, 1'b0); wait_cyc(8);
      rd(0, 8'h40, "R2 fall in high mode");
      wr(10, 8'h00); wait_cyc(4);

      // R10 always-wake source while masked
      wr(4, 8'h0A);
      set_src(3, 1'b1); wait_cyc(8);
      snap = on_cnt;
      set_src(3, 1'b0); wait_cyc(8);
      chk(on_cnt > snap, "R10 masked wake pulse", on_cnt - snap, 1);
      chk(irq == 1'b1, "R10 no line", irq, 1);
      rd(0, 8'h00, "R10 masked not latched");
      wr(4, 8'h00);

      // R11 / R12 sleep suppression and wake sources
      wr(10, 8'h04);
      @(negedge clk); sleep = 1'b1;
      snap = on_cnt;
      set_src(12, 1'b1); wait_cyc(8);
      chk(irq == 1'b1, "R12 line suppressed", irq, 1);
      chk(on_cnt == snap, "R11 non-wake source silent", on_cnt - snap, 0);
      @(negedge clk); sleep = 1'b0;
      wait_cyc(4);
      chk(irq == 1'b0, "R12 line after wake", irq, 0);
      chk(on_req == 1'b1, "R11 line raises request", on_req, 1);
      rd(1, 8'h10, "R12 latched in sleep");
      wait_cyc(4);
      chk(on_req == 1'b0, "R11 request drops", on_req, 0);
      @(negedge clk); sleep = 1'b1;
      snap = on_cnt;
      set_src(14, 1'b1); wait_cyc(8);
      chk(on_cnt > snap, "R11 unmasked wake source", on_cnt - snap, 1);
      chk(irq == 1'b1, "R12 still suppressed", irq, 1);
      rd(1, 8'h40, "R11 wake source latched");
      wr(5, 8'h40);
      set_src(14, 1'b0); wait_cyc(8);
      snap = on_cnt;
      set_src(14, 1'b1); wait_cyc(8);
      chk(on_cnt == snap, "R11 masked wake source silent", on_cnt - snap, 0);
      @(negedge clk); sleep = 1'b0;
      wr(5, 8'h00);

      wait_cyc(10);
      chk(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule